// File: doc/BRIEF.md
# Ten-bit address I2C slave receiver

This block receives write transfers on an I2C bus as a slave with a ten-bit address. It watches the synchronized clock and data lines, finds Start and Stop, shifts in bytes and drives open-drain low-enables: one on the data line for the acknowledge, one on the clock line to stretch the clock. It holds a single eight-bit address register that software loads. The register holds the upper address byte (prefix `11110`, two address bits, and a write bit of 0) while the first address byte comes in. It holds the full lower address byte while the second one comes in.

After each address byte the engine raises an update-address flag and keeps the clock low. Software then writes the other half of the address into the register, and that write releases the clock. Data bytes that follow are acknowledged and placed in a one-entry receive buffer. With stretching enabled, the hardware also clears a clock-release bit and holds the bus after each byte until software sets that bit again. A byte that arrives while the buffer is still full is refused and marked as an overflow.

Top module: `i2c10_slave_rx`

## Requirements
- R1: A Start (data falls while clock is high) sets `start_seen_o` and clears nothing else. It sets `irq_o` only when `start_irq_en_i` is 1.
- R2: After a Start, the first byte is received MSB first. It matches when bits 7:3 are `11110`, bits 7:1 equal `addr_o[7:1]` and bit 0 (write) is 0. A match drives the data line low for the 9th clock pulse and sets `upd_addr_o`, `irq_o` and `full_o`, with the byte in `rdata_o`. A mismatch gets no acknowledge, sets no flag, and the rest of the transfer up to the next Start is ignored.
- R3: After a matching address byte, `scl_lo_o` goes high from the falling edge of the 9th clock pulse onwards. It stays high until an accepted write to the address register. That write also clears `upd_addr_o`.
- R4: The second address byte matches when all 8 bits equal `addr_o`. On a match it is acknowledged and sets `upd_addr_o`, `irq_o` and `full_o`, with the byte in `rdata_o`.
- R5: A second address byte that does not match is not acknowledged. It still sets `upd_addr_o` and `irq_o`. It leaves `full_o` and `rel_o` unchanged, does not hold the clock, and later data bytes are ignored.
- R6: Each data byte after a matched address is acknowledged, stored, and sets `full_o` and `irq_o`. When `stretch_en_i` is 1, `rel_o` drops to 0 and `scl_lo_o` holds the clock after the 9th pulse until a `rel_set_i` pulse. When `stretch_en_i` is 0, `rel_o` is untouched and the clock is not held.
- R7: A `rd_i` pulse clears `full_o`.
- R8: A write to the address register is ignored while the acknowledge sequence runs, that is from the falling clock edge after bit 8 up to the falling edge of the 9th pulse.
- R9: A Stop (data rises while clock is high) returns the engine to idle. It clears `upd_addr_o` and `start_seen_o` and releases both lines.
- R10: A repeated Start during a transfer starts address reception again with the upper address byte.
- R11: A data byte that arrives while `full_o` is 1 is not acknowledged. It sets `ovf_o` and leaves `rdata_o` unchanged. `ovf_clr_i` clears `ovf_o`.
- R12: `irq_clr_i` clears `irq_o`. The bus inputs go through a two-stage synchronizer, and the reset values are: address register `8'hF6`, `rel_o` 1, all flags 0, lines released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| scl_lo_o | output | 1 | Pull bus clock low (stretch) |
| sda_lo_o | output | 1 | Pull bus data low (acknowledge) |
| addr_wr_i | input | 1 | Address register write strobe |
| addr_wdata_i | input | 8 | Address register write value |
| addr_o | output | 8 | Address register contents |
| rd_i | input | 1 | Receive buffer read strobe |
| rdata_o | output | 8 | Receive buffer contents |
| full_o | output | 1 | Buffer-full flag |
| irq_o | output | 1 | Interrupt flag |
| irq_clr_i | input | 1 | Clear interrupt flag |
| start_seen_o | output | 1 | Start seen since last Stop |
| upd_addr_o | output | 1 | Address register must be reloaded |
| ovf_o | output | 1 | Receive overflow flag |
| ovf_clr_i | input | 1 | Clear overflow flag |
| stretch_en_i | input | 1 | Hold the clock after each data byte |
| start_irq_en_i | input | 1 | Raise interrupt on Start |
| rel_set_i | input | 1 | Set the clock-release bit |
| rel_o | output | 1 | Clock-release bit |

## Verification
A wrong phase or bit count shows at the bus within one byte. The acknowledge lands on the wrong byte or fails to come, or the clock is held during address bits, so the bus master stalls or sees a refusal on the 9th pulse. A stale buffer-full or update-address flag shows as a missing or repeated item in the stream of received bytes, or as a bus that never gets released. A compare against the wrong half of the address register shows on the very next address byte as a refusal.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [4:0] HI_PREFIX = 5'b11110;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HI,
        PH_LO,
        PH_DATA,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    function automatic logic hi_match(input logic [BYTE_W-1:0] rx,
                                      input logic [BYTE_W-1:0] a);
        return (rx[7:3] == HI_PREFIX) && (rx[7:1] == a[7:1]) && !rx[0];
    endfunction

    function automatic logic lo_match(input logic [BYTE_W-1:0] rx,
                                      input logic [BYTE_W-1:0] a);
        return rx == a;
    endfunction

endpackage

// File: rtl/i2c10_sync.sv
module i2c10_sync
    import i2c10_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_d;
    logic              sda_d;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_ff[0] <= 1'b1;
                    sda_ff[0] <= 1'b1;
                end else begin
                    scl_ff[0] <= scl_i;
                    sda_ff[0] <= sda_i;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_ff[g] <= 1'b1;
                    sda_ff[g] <= 1'b1;
                end else begin
                    scl_ff[g] <= scl_ff[g-1];
                    sda_ff[g] <= sda_ff[g-1];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_ff[STAGES-1];
            sda_d <= sda_ff[STAGES-1];
        end
    end

    always_comb begin
        ev.scl   = scl_ff[STAGES-1];
        ev.sda   = sda_ff[STAGES-1];
        ev.start = scl_d && ev.scl && sda_d && !ev.sda;
        ev.stop  = scl_d && ev.scl && !sda_d && ev.sda;
        ev.rise  = !scl_d && ev.scl;
        ev.fall  = scl_d && !ev.scl;
    end

endmodule

// File: rtl/i2c10_shifter.sv
module i2c10_shifter
    import i2c10_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    output logic [BYTE_W-1:0] byte_q,
    output logic              byte_done,
    output logic              ack_end,
    output logic              ack_busy
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || ev.start || ev.stop) begin
            cnt      <= '0;
            ack_busy <= 1'b0;
            byte_q   <= '0;
        end else begin
            if (ev.rise && (cnt < CNT_W'(BYTE_W))) begin
                byte_q <= {byte_q[BYTE_W-2:0], ev.sda};
                cnt    <= cnt + 1'b1;
            end
            if (ev.fall) begin
                if (ack_busy) begin
                    ack_busy <= 1'b0;
                    cnt      <= '0;
                end else if (cnt == CNT_W'(BYTE_W)) begin
                    ack_busy <= 1'b1;
                end
            end
        end
    end

    assign byte_done = ev.fall && !ack_busy && (cnt == CNT_W'(BYTE_W));
    assign ack_end   = ev.fall && ack_busy;

    // R8: the acknowledge window opens right after a completed byte
    p_ack_window_r8: assert property (@(posedge clk) disable iff (rst)
        byte_done |=> ack_busy);

endmodule

// File: rtl/i2c10_slave_rx.sv
module i2c10_slave_rx
    import i2c10_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  RST_ADDR    = 8'hF6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_lo_o,
    output logic       sda_lo_o,
    input  logic       addr_wr_i,
    input  logic [7:0] addr_wdata_i,
    output logic [7:0] addr_o,
    input  logic       rd_i,
    output logic [7:0] rdata_o,
    output logic       full_o,
    output logic       irq_o,
    input  logic       irq_clr_i,
    output logic       start_seen_o,
    output logic       upd_addr_o,
    output logic       ovf_o,
    input  logic       ovf_clr_i,
    input  logic       stretch_en_i,
    input  logic       start_irq_en_i,
    input  logic       rel_set_i,
    output logic       rel_o
);

    bus_ev_t           ev;
    logic [BYTE_W-1:0] rx_byte;
    logic              byte_done;
    logic              ack_end;
    logic              ack_busy;

    phase_e            phase;
    logic              addr_wait;
    logic              data_wait;
    logic              addr_wr_ok;
    logic              active;
    logic              load_buf;

    i2c10_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c10_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .byte_q    (rx_byte),
        .byte_done (byte_done),
        .ack_end   (ack_end),
        .ack_busy  (ack_busy)
    );

    assign addr_wr_ok = addr_wr_i && !ack_busy;
    assign active     = (phase == PH_HI) || (phase == PH_LO) || (phase == PH_DATA);

    always_comb begin
        load_buf = 1'b0;
        if (byte_done) begin
            unique case (phase)
                PH_HI:   load_buf = hi_match(rx_byte, addr_o);
                PH_LO:   load_buf = lo_match(rx_byte, addr_o);
                PH_DATA: load_buf = !full_o;
                default: load_buf = 1'b0;
            endcase
        end
    end

    assign scl_lo_o = active && !ack_busy && (addr_wait || data_wait);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase        <= PH_IDLE;
            addr_o       <= RST_ADDR;
            rdata_o      <= '0;
            full_o       <= 1'b0;
            irq_o        <= 1'b0;
            start_seen_o <= 1'b0;
            upd_addr_o   <= 1'b0;
            ovf_o        <= 1'b0;
            rel_o        <= 1'b1;
            sda_lo_o     <= 1'b0;
            addr_wait    <= 1'b0;
            data_wait    <= 1'b0;
        end else begin
            // software side first, bus events may override
            if (irq_clr_i) irq_o <= 1'b0;
            if (ovf_clr_i) ovf_o <= 1'b0;
            if (rd_i)      full_o <= 1'b0;
            if (rel_set_i) begin
                rel_o     <= 1'b1;
                data_wait <= 1'b0;
            end
            if (addr_wr_ok) begin
                addr_o     <= addr_wdata_i;
                upd_addr_o <= 1'b0;
                addr_wait  <= 1'b0;
            end

            if (ack_end) sda_lo_o <= 1'b0;

            if (load_buf) begin
                rdata_o <= rx_byte;
                full_o  <= 1'b1;
            end

            if (byte_done) begin
                unique case (phase)
                    PH_HI: begin
                        if (load_buf) begin
                            sda_lo_o   <= 1'b1;
                            upd_addr_o <= 1'b1;
                            irq_o      <= 1'b1;
                            addr_wait  <= 1'b1;
                            phase      <= PH_LO;
                        end else begin
                            phase <= PH_SKIP;
                        end
                    end
                    PH_LO: begin
                        upd_addr_o <= 1'b1;
                        irq_o      <= 1'b1;
                        if (load_buf) begin
                            sda_lo_o  <= 1'b1;
                            addr_wait <= 1'b1;
                            phase     <= PH_DATA;
                        end else begin
                            phase <= PH_SKIP;
                        end
                    end
                    PH_DATA: begin
                        irq_o <= 1'b1;
                        if (load_buf) begin
                            sda_lo_o <= 1'b1;
                            if (stretch_en_i) begin
                                rel_o     <= 1'b0;
                                data_wait <= 1'b1;
                            end
                        end else begin
                            ovf_o <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end

            if (ev.start) begin
                phase        <= PH_HI;
                start_seen_o <= 1'b1;
                if (start_irq_en_i) irq_o <= 1'b1;
                sda_lo_o     <= 1'b0;
                addr_wait    <= 1'b0;
                data_wait    <= 1'b0;
            end else if (ev.stop) begin
                phase        <= PH_IDLE;
                start_seen_o <= 1'b0;
                upd_addr_o   <= 1'b0;
                sda_lo_o     <= 1'b0;
                addr_wait    <= 1'b0;
                data_wait    <= 1'b0;
            end
        end
    end

    // R1: Start is recorded
    p_start_seen_r1: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> start_seen_o);

    // R1: masked Start leaves the interrupt low
    p_start_masked_r1: assert property (@(posedge clk) disable iff (rst)
        (ev.start && !start_irq_en_i && !irq_o) |=> !irq_o);

    // R2: acknowledge drive only begins while the clock is low
    p_ack_scl_low_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_lo_o) |-> !ev.scl);

    // R3: stretching only begins while the clock is low
    p_hold_scl_low_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_lo_o) |-> !ev.scl);

    // R7: a read with no new byte empties the buffer
    p_read_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_i && !load_buf) |=> !full_o);

    // R8: writes inside the acknowledge window are dropped
    p_addr_locked_r8: assert property (@(posedge clk) disable iff (rst)
        (addr_wr_i && ack_busy) |=> $stable(addr_o));

    // R9: Stop releases the bus and clears the update flag
    p_stop_idle_r9: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (!upd_addr_o && !scl_lo_o && !sda_lo_o));

    // R11: a byte into a full buffer is refused
    p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
        (byte_done && (phase == PH_DATA) && full_o && !rd_i) |=> (ovf_o && !sda_lo_o));

endmodule

// File: tb/i2c10_slave_rx_tb.sv
module i2c10_slave_rx_tb;

    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       scl_line;
    logic       sda_line;
    logic       scl_lo_o, sda_lo_o;
    logic       addr_wr_i = 1'b0;
    logic [7:0] addr_wdata_i = '0;
    logic [7:0] addr_o;
    logic       rd_i = 1'b0;
    logic [7:0] rdata_o;
    logic       full_o, irq_o, start_seen_o, upd_addr_o, ovf_o, rel_o;
    logic       irq_clr_i = 1'b0;
    logic       ovf_clr_i = 1'b0;
    logic       stretch_en_i = 1'b0;
    logic       start_irq_en_i = 1'b0;
    logic       rel_set_i = 1'b0;

    int         n_chk = 0;
    int         n_fail = 0;
    logic [7:0] exp_q[$];
    bit         mon_en = 1'b1;
    bit         ack;

    always #2.5 clk = ~clk;

    assign scl_line = scl_m & ~scl_lo_o;
    assign sda_line = sda_m & ~sda_lo_o;

    i2c10_slave_rx u_dut (
        .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
        .scl_lo_o(scl_lo_o), .sda_lo_o(sda_lo_o),
        .addr_wr_i(addr_wr_i), .addr_wdata_i(addr_wdata_i), .addr_o(addr_o),
        .rd_i(rd_i), .rdata_o(rdata_o), .full_o(full_o), .irq_o(irq_o),
        .irq_clr_i(irq_clr_i), .start_seen_o(start_seen_o), .upd_addr_o(upd_addr_o),
        .ovf_o(ovf_o), .ovf_clr_i(ovf_clr_i), .stretch_en_i(stretch_en_i),
        .start_irq_en_i(start_irq_en_i), .rel_set_i(rel_set_i), .rel_o(rel_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        while (!scl_line) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_n(H);
        scl_m = 1'b1; wait_scl_high(); wait_n(H);
        sda_m = 1'b0; wait_n(H);
        scl_m = 1'b0; wait_n(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_n(H);
        scl_m = 1'b1; wait_scl_high(); wait_n(H);
        sda_m = 1'b1; wait_n(H);
    endtask

    // driver: sends a byte; pushes the expected buffer item when told to
    task automatic send_byte(input logic [7:0] b, input bit expect_buf,
                             input bit poke, output bit acked);
        if (expect_buf) exp_q.push_back(b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_n(H);
            scl_m = 1'b1; wait_scl_high(); wait_n(H);
            scl_m = 1'b0;
        end
        sda_m = 1'b1; wait_n(H);
        scl_m = 1'b1; wait_scl_high(); wait_n(H/2);
        acked = !sda_line;
        if (poke) begin
            addr_wdata_i = 8'h00; addr_wr_i = 1'b1; wait_n(1); addr_wr_i = 1'b0;
        end
        wait_n(H/2);
        scl_m = 1'b0; wait_n(H);
    endtask

    task automatic sw_addr(input logic [7:0] v);
        addr_wdata_i = v; addr_wr_i = 1'b1; wait_n(1); addr_wr_i = 1'b0; wait_n(2);
    endtask

    task automatic pulse_irq_clr();
        irq_clr_i = 1'b1; wait_n(1); irq_clr_i = 1'b0; wait_n(1);
    endtask

    // monitor: pops expected bytes as the buffer fills, then reads it
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && mon_en && full_o && !rd_i) begin
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R6: actual %0h expected none", rdata_o);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    if (rdata_o !== e) begin
                        n_fail++;
                        $display("FAIL R6: actual %0h expected %0h", rdata_o, e);
                    end
                end
                rd_i = 1'b1;
                @(negedge clk);
                rd_i = 1'b0;
                @(negedge clk);
                check("R7", full_o, 1'b0);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        wait_n(4);
        rst = 1'b0;
        wait_n(2);
        // R12 reset state
        check("R12", addr_o, 8'hF6);
        check("R12", {full_o, irq_o, start_seen_o, upd_addr_o, ovf_o}, 5'b0);
        check("R12", {rel_o, scl_lo_o, sda_lo_o}, 3'b100);

        // R1 start with interrupt enabled
        start_irq_en_i = 1'b1;
        bus_start();
        check("R1", start_seen_o, 1'b1);
        check("R1", irq_o, 1'b1);
        pulse_irq_clr();
        check("R12", irq_o, 1'b0);

        // R2 matching high byte, R8 write during acknowledge
        send_byte(8'hF6, 1'b1, 1'b1, ack);
        check("R2", ack, 1'b1);
        check("R2", upd_addr_o, 1'b1);
        check("R2", irq_o, 1'b1);
        check("R8", addr_o, 8'hF6);
        check("R3", scl_lo_o, 1'b1);
        wait_n(20);
        check("R3", scl_lo_o, 1'b1);
        sw_addr(8'hA5);
        check("R3", scl_lo_o, 1'b0);
        check("R3", upd_addr_o, 1'b0);
        check("R3", addr_o, 8'hA5);

        // R4 matching low byte
        pulse_irq_clr();
        send_byte(8'hA5, 1'b1, 1'b0, ack);
        check("R4", ack, 1'b1);
        check("R4", upd_addr_o, 1'b1);
        check("R4", irq_o, 1'b1);
        check("R3", scl_lo_o, 1'b1);
        sw_addr(8'hF6);
        check("R3", scl_lo_o, 1'b0);

        // R6 data with stretching
        stretch_en_i = 1'b1;
        pulse_irq_clr();
        send_byte(8'h3C, 1'b1, 1'b0, ack);
        check("R6", ack, 1'b1);
        check("R6", irq_o, 1'b1);
        check("R6", rel_o, 1'b0);
        check("R6", scl_lo_o, 1'b1);
        rel_set_i = 1'b1; wait_n(1); rel_set_i = 1'b0; wait_n(2);
        check("R6", rel_o, 1'b1);
        check("R6", scl_lo_o, 1'b0);

        // R6 data without stretching
        stretch_en_i = 1'b0;
        send_byte(8'hC3, 1'b1, 1'b0, ack);
        check("R6", ack, 1'b1);
        check("R6", rel_o, 1'b1);
        check("R6", scl_lo_o, 1'b0);

        // R11 overflow
        wait_n(10);
        mon_en = 1'b0;
        send_byte(8'h11, 1'b1, 1'b0, ack);
        check("R11", ack, 1'b1);
        check("R11", full_o, 1'b1);
        send_byte(8'h22, 1'b0, 1'b0, ack);
        check("R11", ack, 1'b0);
        check("R11", ovf_o, 1'b1);
        check("R11", rdata_o, 8'h11);
        mon_en = 1'b1;
        wait_n(10);
        ovf_clr_i = 1'b1; wait_n(1); ovf_clr_i = 1'b0; wait_n(1);
        check("R11", ovf_o, 1'b0);

        // R9 stop
        bus_stop();
        check("R9", start_seen_o, 1'b0);
        check("R9", {scl_lo_o, sda_lo_o}, 2'b00);

        // R1 masked start, R5 low mismatch
        start_irq_en_i = 1'b0;
        pulse_irq_clr();
        bus_start();
        check("R1", start_seen_o, 1'b1);
        check("R1", irq_o, 1'b0);
        send_byte(8'hF6, 1'b1, 1'b0, ack);
        check("R2", ack, 1'b1);
        sw_addr(8'hA5);
        wait_n(10);
        pulse_irq_clr();
        send_byte(8'h5A, 1'b0, 1'b0, ack);
        check("R5", ack, 1'b0);
        check("R5", upd_addr_o, 1'b1);
        check("R5", irq_o, 1'b1);
        check("R5", full_o, 1'b0);
        check("R5", rel_o, 1'b1);
        check("R5", scl_lo_o, 1'b0);
        sw_addr(8'hF6);
        pulse_irq_clr();
        send_byte(8'h77, 1'b0, 1'b0, ack);
        check("R5", ack, 1'b0);
        check("R5", {irq_o, full_o}, 2'b00);

        // R10 repeated start
        bus_start();
        send_byte(8'hF6, 1'b1, 1'b0, ack);
        check("R10", ack, 1'b1);
        sw_addr(8'hA5);
        send_byte(8'hA5, 1'b1, 1'b0, ack);
        check("R10", ack, 1'b1);
        sw_addr(8'hF6);
        send_byte(8'h99, 1'b1, 1'b0, ack);
        check("R10", ack, 1'b1);
        bus_stop();
        check("R9", upd_addr_o, 1'b0);

        // R2 mismatching high byte
        pulse_irq_clr();
        wait_n(10);
        bus_start();
        send_byte(8'hF4, 1'b0, 1'b0, ack);
        check("R2", ack, 1'b0);
        check("R2", {upd_addr_o, irq_o, full_o}, 3'b000);
        bus_stop();

        wait_n(20);
        check("R6", exp_q.size(), 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule